// File: doc/BRIEF.md
# Address Region Access Guard with Fault Record

The block sits beside a memory port and judges every bus reference against up to sixteen programmable address windows. Each window carries an inclusive start and end address at 32-byte granularity, a table of read, write and execute rights for each requester in user and supervisor mode, and an enable flag. A reference is allowed when at least one enabled window covers its address and grants the needed right. The allow output is a purely combinational function of the reference inputs and the programmed windows.

When a valid reference is refused, the block latches a fault record. The record holds the faulting address, a per-window vector of "covered and refused" bits, the requester's master number and process identifier, the mode and kind attribute code, and the read/write flag. The record is sticky: it keeps the first fault until software clears its valid flag. Software reaches both the windows and the record through a small word-addressed register port. Reads return data combinationally and writes take effect on the clock edge.

Top module: `mg_guard_top`

## Requirements
- R1: After reset every window is disabled, so every reference is refused; the fault record's valid flag (status word 2, bit 0) and the captured address (word 0) read zero.
- R2: A window at register words 16+4r+w (r = window, w = word 0..3) covers an address when it is enabled and {word0[31:5],5'h00} <= address <= {word1[31:5],5'h1F}; reading word 1 back returns the end address with bits 4:0 set.
- R3: Word 2 holds six rights per master at bits 6m+5..6m: bit 0 user read, 1 user write, 2 user execute, 3 supervisor read, 4 supervisor write, 5 supervisor execute. A data reference needs the read or write right, and an instruction reference needs the execute right, in the reference's mode.
- R4: A reference is allowed when any covering window grants the right; rights from overlapping windows are OR-ed.
- R5: Any write to word 0 of a window disables it; writing word 3 with bit 0 set enables it, and word 3 bit 0 reads back the enable flag.
- R6: On a clock edge where ref_valid is high and the reference is refused while no fault is held, the record captures the address (word 0), the read/write flag (detail bit 0: 0 read, 1 write) and the master number (detail bits 7:4), and sets the valid flag.
- R7: Detail bits 31:16 hold one bit per window, set when that window covered the faulting reference; all zero means that no window covered it.
- R8: Detail bits 3:1 hold the attribute code {supervisor, data} (000 user instruction, 001 user data, 010 supervisor instruction, 011 supervisor data) and bits 15:8 the process identifier. For a requester that is not a core, the reference is judged as supervisor data, the record shows 011 and the identifier reads 0.
- R9: While the valid flag is set, later faults do not change the record; writing 1 to status bit 0 clears the flag, and a fault in that same cycle is captured.
- R10: A refused reference with ref_valid low leaves the record unchanged.
- R11: A master number at or above NUM_MASTERS has no rights and is always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (7) | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| ref_valid | input | 1 | Reference is presented this cycle |
| ref_addr | input | ADDR_W (32) | Reference byte address |
| ref_master | input | 4 | Logical master number |
| ref_pid | input | 8 | Process identifier |
| ref_is_core | input | 1 | Requester is a processor core |
| ref_sup | input | 1 | Supervisor mode (1) or user mode (0) |
| ref_data | input | 1 | Data access (1) or instruction fetch (0) |
| ref_write | input | 1 | Write (1) or read (0) |
| ref_allow | output | 1 | Reference is permitted |

## Verification
The decision is tried with addresses just outside and exactly on both inclusive window edges, which tells apart off-by-one and granularity errors in the compare. References in the overlap of two windows, where only one of them grants the needed right, separate an OR of grants from a first-hit or AND scheme. Mode, kind and master are each swept while the others are held, so a rights bit taken from the wrong position shows up as a wrong decision. Fault capture is driven with a miss, with a single-window refusal and with an overlap refusal, which separates the three shapes of the window vector, and with a non-core requester, a repeated fault, a refusal without ref_valid, and a clear.

// File: rtl/mg_pkg.sv
package mg_pkg;
   // rights held per master inside descriptor word 2
   localparam int RIGHTS_PER_MASTER = 6;
   localparam int MAX_REGIONS       = 16;
   localparam int DATA_W            = 32;
   localparam int MN_W              = 4;
   localparam int PID_W             = 8;
   localparam int GRAN_BITS         = 5;

   // register word map
   localparam int REG_ERR_ADDR   = 0;
   localparam int REG_ERR_DETAIL = 1;
   localparam int REG_ERR_STATUS = 2;
   localparam int REG_RGN_BASE   = 16;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_EXEC  = 2'd2
   } kind_e;

   typedef struct packed {
      logic [MAX_REGIONS-1:0] hit_vec;
      logic [PID_W-1:0]       pid;
      logic [MN_W-1:0]        master;
      logic [2:0]             attr;
      logic                   rw;
   } fault_rec_t;
endpackage

// File: rtl/mg_region.sv
module mg_region
   import mg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_MASTERS = 4,
   localparam int PERM_W     = NUM_MASTERS * RIGHTS_PER_MASTER
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        word_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [MN_W-1:0]   ref_master,
   input  logic [2:0]        ref_right,
   output logic              hit,
   output logic              grant,
   output logic [DATA_W-1:0] rd_word [4]
);
   logic [ADDR_W-1:GRAN_BITS] start_q, end_q;
   logic [PERM_W-1:0]         perm_q;
   logic                      valid_q;
   logic                      perm_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
         perm_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (word_we[0]) start_q <= wdata[ADDR_W-1:GRAN_BITS];
         if (word_we[1]) end_q   <= wdata[ADDR_W-1:GRAN_BITS];
         if (word_we[2]) perm_q  <= wdata[PERM_W-1:0];
         if (word_we[0])      valid_q <= 1'b0;
         else if (word_we[3]) valid_q <= wdata[0];
      end
   end

   always_comb begin
      hit = valid_q
         && (ref_addr >= {start_q, {GRAN_BITS{1'b0}}})
         && (ref_addr <= {end_q, {GRAN_BITS{1'b1}}});
   end

   always_comb begin
      perm_bit = 1'b0;
      for (int m = 0; m < NUM_MASTERS; m++) begin
         if (ref_master == MN_W'(m))
            perm_bit = perm_q[m*RIGHTS_PER_MASTER + int'(ref_right)];
      end
   end

   assign grant = hit & perm_bit;

   always_comb begin
      rd_word[0] = DATA_W'({start_q, {GRAN_BITS{1'b0}}});
      rd_word[1] = DATA_W'({end_q, {GRAN_BITS{1'b1}}});
      rd_word[2] = DATA_W'(perm_q);
      rd_word[3] = DATA_W'(valid_q);
   end

   // R5
   wr0_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_we[0] |=> !hit && !grant);

   // R3
   grant_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> hit);
endmodule

// File: rtl/mg_fault_capture.sv
module mg_fault_capture
   import mg_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault,
   input  logic              clear,
   input  logic [ADDR_W-1:0] ref_addr,
   input  fault_rec_t        rec_in,
   output logic              err_valid,
   output logic [ADDR_W-1:0] err_addr,
   output fault_rec_t        err_rec
);
   logic take;

   assign take = fault && (!err_valid || clear);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_valid <= 1'b0;
         err_addr  <= '0;
         err_rec   <= '0;
      end else begin
         if (take) begin
            err_addr <= ref_addr;
            err_rec  <= rec_in;
         end
         err_valid <= take || (err_valid && !clear);
      end
   end

   // R9
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid && !clear |=> err_valid && $stable(err_addr) && $stable(err_rec));

   // R6
   first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !err_valid |=> err_valid && err_addr == $past(ref_addr));

   // R10
   quiet_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault && !err_valid |=> !err_valid);
endmodule

// File: rtl/mg_guard_top.sv
module mg_guard_top
   import mg_pkg::*;
#(
   parameter int NUM_REGIONS = 16,
   parameter int NUM_MASTERS = 4,
   parameter int ADDR_W      = 32,
   localparam int CFG_AW     = $clog2(REG_RGN_BASE + 4*NUM_REGIONS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              ref_valid,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [3:0]        ref_master,
   input  logic [7:0]        ref_pid,
   input  logic              ref_is_core,
   input  logic              ref_sup,
   input  logic              ref_data,
   input  logic              ref_write,
   output logic              ref_allow
);
   generate
      if (NUM_REGIONS < 1 || NUM_REGIONS > MAX_REGIONS) begin : g_bad_regions
         $error("NUM_REGIONS must lie in 1..16");
      end
      if (NUM_MASTERS < 1 || NUM_MASTERS * RIGHTS_PER_MASTER > DATA_W) begin : g_bad_masters
         $error("NUM_MASTERS rights must fit one 32-bit word");
      end
      if (ADDR_W <= GRAN_BITS || ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must lie in 6..32");
      end
   endgenerate

   // effective attributes: non-core requesters are treated as supervisor data
   logic       eff_sup, eff_data;
   logic [7:0] eff_pid;
   kind_e      kind;
   logic [2:0] right_idx;

   always_comb begin
      eff_sup  = ref_is_core ? ref_sup  : 1'b1;
      eff_data = ref_is_core ? ref_data : 1'b1;
      eff_pid  = ref_is_core ? ref_pid  : '0;
      if (!eff_data)      kind = KIND_EXEC;
      else if (ref_write) kind = KIND_WRITE;
      else                kind = KIND_READ;
      right_idx = (eff_sup ? 3'd3 : 3'd0) + {1'b0, kind};
   end

   logic [NUM_REGIONS-1:0] hit_vec, grant_vec;
   logic [DATA_W-1:0]      rgn_rd [NUM_REGIONS][4];

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
      logic [3:0] word_we;
      for (genvar w = 0; w < 4; w++) begin : g_we
         assign word_we[w] = cfg_we
            && (cfg_addr == CFG_AW'(REG_RGN_BASE + 4*r + w));
      end
      mg_region #(
         .ADDR_W      (ADDR_W),
         .NUM_MASTERS (NUM_MASTERS)
      ) u_rgn (
         .clk        (clk),
         .rst_n      (rst_n),
         .word_we    (word_we),
         .wdata      (cfg_wdata),
         .ref_addr   (ref_addr),
         .ref_master (ref_master),
         .ref_right  (right_idx),
         .hit        (hit_vec[r]),
         .grant      (grant_vec[r]),
         .rd_word    (rgn_rd[r])
      );
   end

   assign ref_allow = |grant_vec;

   fault_rec_t        rec_in, err_rec;
   logic              err_valid, err_clear, fault;
   logic [ADDR_W-1:0] err_addr;

   always_comb begin
      rec_in.hit_vec = MAX_REGIONS'(hit_vec & {NUM_REGIONS{!ref_allow}});
      rec_in.pid     = eff_pid;
      rec_in.master  = ref_master;
      rec_in.attr    = {1'b0, eff_sup, eff_data};
      rec_in.rw      = ref_write;
   end

   assign fault     = ref_valid && !ref_allow;
   assign err_clear = cfg_we && (cfg_addr == CFG_AW'(REG_ERR_STATUS)) && cfg_wdata[0];

   mg_fault_capture #(
      .ADDR_W (ADDR_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault     (fault),
      .clear     (err_clear),
      .ref_addr  (ref_addr),
      .rec_in    (rec_in),
      .err_valid (err_valid),
      .err_addr  (err_addr),
      .err_rec   (err_rec)
   );

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == CFG_AW'(REG_ERR_ADDR))        cfg_rdata = DATA_W'(err_addr);
      else if (cfg_addr == CFG_AW'(REG_ERR_DETAIL)) cfg_rdata = err_rec;
      else if (cfg_addr == CFG_AW'(REG_ERR_STATUS)) cfg_rdata = DATA_W'(err_valid);
      else begin
         for (int r = 0; r < NUM_REGIONS; r++) begin
            for (int w = 0; w < 4; w++) begin
               if (cfg_addr == CFG_AW'(REG_RGN_BASE + 4*r + w))
                  cfg_rdata = rgn_rd[r][w];
            end
         end
      end
   end

   // R4
   allow_needs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_allow |-> (hit_vec != '0));

   // R8
   noncore_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !err_valid && !ref_is_core |=> err_rec.pid == '0 && err_rec.attr == 3'b011);

   // R7
   vector_zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !err_valid && (hit_vec == '0) |=> err_rec.hit_vec == '0);
endmodule

// File: tb/tb_mg_guard_top.sv
module tb_mg_guard_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        ref_valid = 1'b0;
   logic [31:0] ref_addr = '0;
   logic [3:0]  ref_master = '0;
   logic [7:0]  ref_pid = '0;
   logic        ref_is_core = 1'b1;
   logic        ref_sup = 1'b0;
   logic        ref_data = 1'b1;
   logic        ref_write = 1'b0;
   logic        ref_allow;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mg_guard_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ref_valid(ref_valid),
      .ref_addr(ref_addr), .ref_master(ref_master), .ref_pid(ref_pid),
      .ref_is_core(ref_is_core), .ref_sup(ref_sup), .ref_data(ref_data),
      .ref_write(ref_write), .ref_allow(ref_allow)
   );

   // {addr, master, sup, data, write, expected allow}
   localparam logic [39:0] VEC [13] = '{
      {32'h0000_1000, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 start edge, user read
      {32'h0000_0FFF, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 below start
      {32'h0000_1FFF, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 inclusive end
      {32'h0000_2020, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 past end
      {32'h0000_201F, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 window 1 end, user write
      {32'h0000_1004, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 no user write
      {32'h0000_1804, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 overlap, OR of grants
      {32'h0000_1804, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 user execute absent
      {32'h0000_1804, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 supervisor execute
      {32'h0000_1100, 4'd1, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 master 1 sup read
      {32'h0000_1100, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 master 1 user read
      {32'h0000_1100, 4'd1, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 master 1 sup write
      {32'h0000_1100, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0}  // R11 master out of range
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [6:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   task automatic set_ref(input logic [31:0] a, input logic [3:0] m, input logic s,
                          input logic dt, input logic w);
      ref_addr = a; ref_master = m; ref_sup = s; ref_data = dt; ref_write = w;
   endtask

   task automatic fire(input logic [31:0] a, input logic [3:0] m, input logic core,
                       input logic [7:0] pid, input logic s, input logic dt, input logic w);
      @(negedge clk);
      set_ref(a, m, s, dt, w);
      ref_is_core = core; ref_pid = pid; ref_valid = 1'b1;
      @(negedge clk);
      ref_valid = 1'b0; ref_is_core = 1'b1; ref_pid = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cfg_read(7'd2, rd); check(rd, 32'h0, "R1 status");
      cfg_read(7'd0, rd); check(rd, 32'h0, "R1 err addr");
      set_ref(32'h1000, 4'd0, 1'b1, 1'b1, 1'b0); #1;
      check({31'b0, ref_allow}, 32'h0, "R1 refused when disabled");

      // program windows
      cfg_write(7'd16, 32'h0000_1000); cfg_write(7'd17, 32'h0000_1FE0);
      cfg_write(7'd18, 32'h0000_0239); cfg_write(7'd19, 32'h1);
      cfg_write(7'd20, 32'h0000_1800); cfg_write(7'd21, 32'h0000_2000);
      cfg_write(7'd22, 32'h0000_0002); cfg_write(7'd23, 32'h1);
      cfg_write(7'd24, 32'h0000_8000); cfg_write(7'd25, 32'h0000_8000);
      cfg_write(7'd26, 32'h0003_F000); cfg_write(7'd27, 32'h1);
      cfg_read(7'd17, rd); check(rd, 32'h0000_1FFF, "R2 end readback");

      for (int i = 0; i < 13; i++) begin
         @(negedge clk);
         set_ref(VEC[i][39:8], VEC[i][7:4], VEC[i][3], VEC[i][2], VEC[i][1]);
         #1;
         check({31'b0, ref_allow}, {31'b0, VEC[i][0]}, $sformatf("R2/R3/R4/R11 vector %0d", i));
      end

      // R5 word-0 write disables, word-3 enables
      @(negedge clk); set_ref(32'h8010, 4'd2, 1'b1, 1'b1, 1'b0); #1;
      check({31'b0, ref_allow}, 32'h1, "R5 window 2 enabled");
      cfg_write(7'd24, 32'h0000_8000); #1;
      check({31'b0, ref_allow}, 32'h0, "R5 disabled after word0 write");
      cfg_read(7'd27, rd); check(rd, 32'h0, "R5 enable readback");
      cfg_write(7'd27, 32'h1); #1;
      check({31'b0, ref_allow}, 32'h1, "R5 re-enabled");

      // R6 R7 single-window refusal
      fire(32'h1004, 4'd0, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b1);
      cfg_read(7'd2, rd); check(rd, 32'h1, "R6 valid set");
      cfg_read(7'd0, rd); check(rd, 32'h0000_1004, "R6 address");
      cfg_read(7'd1, rd); check(rd, 32'h0001_5A03, "R6 R7 R8 detail");

      // R9 sticky
      fire(32'h0FFF, 4'd0, 1'b1, 8'h22, 1'b0, 1'b1, 1'b0);
      cfg_read(7'd0, rd); check(rd, 32'h0000_1004, "R9 address held");
      cfg_read(7'd1, rd); check(rd, 32'h0001_5A03, "R9 detail held");
      cfg_write(7'd2, 32'h1);
      cfg_read(7'd2, rd); check(rd, 32'h0, "R9 cleared");

      // R10 refusal without ref_valid
      @(negedge clk); set_ref(32'h0FFF, 4'd0, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      cfg_read(7'd2, rd); check(rd, 32'h0, "R10 no capture");

      // R8 R7 non-core miss
      fire(32'h0FFF, 4'd3, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0);
      cfg_read(7'd1, rd); check(rd, 32'h0000_0036, "R8 R7 non-core miss detail");
      cfg_read(7'd0, rd); check(rd, 32'h0000_0FFF, "R6 miss address");

      // R9 clear and fault in the same cycle: fault captured
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 7'd2; cfg_wdata = 32'h1;
      set_ref(32'h1804, 4'd0, 1'b0, 1'b0, 1'b0); ref_pid = 8'h11; ref_valid = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; ref_valid = 1'b0; ref_pid = '0;
      cfg_read(7'd2, rd); check(rd, 32'h1, "R9 capture with clear");
      cfg_read(7'd1, rd); check(rd, 32'h0003_1100, "R7 overlap vector detail");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule